// File: doc/BRIEF.md
# Telephone keypad scanner with confirmation beep

This block reads a twelve-key telephone-style keypad wired as four row lines and three column lines. When a scan is requested it pulls each row low in turn, lets the lines settle, and reads the column inputs. A low column marks a pressed key, which is turned directly into its ASCII character. A new press is stored and confirmed with a short burst of tones on a buzzer output.

While the same key stays down, the block keeps rescanning without sounding the buzzer again. It returns only once a complete pass sees no key at all. It then raises a one-clock completion strobe and presents the stored character. If nothing was pressed during the call, the character from the previous call is presented unchanged.

Timing is set by three parameters: the settling wait in clocks, the length of one millisecond in clocks, and the number of tone periods per confirmation.

Top module: `keypad_scanner`

## Requirements
- R1: Outside a scan all four row outputs are high. During a scan at most one row is low at a time, in the order row 0, 1, 2, 3, with a cycle of all rows high after each row before the next one goes low.
- R2: Each row stays low for SETTLE_CLKS+1 cycles, and the columns are read only in the last of those cycles.
- R3: Column inputs are active low. col_n[0] is the left column. The characters are 8'h31, 8'h32, 8'h33 on row 0, 8'h34, 8'h35, 8'h36 on row 1, 8'h37, 8'h38, 8'h39 on row 2, and 8'h2A ('*'), 8'h30 ('0'), 8'h23 ('#') on row 3.
- R4: When several keys are down in one pass, the one read last wins: a higher row beats a lower row, and within a row a higher column index beats a lower one.
- R5: On the first pass of a call that finds a key, key_code takes the new character and buzz produces BEEP_COUNT periods, each MS_CLKS cycles high then MS_CLKS cycles low.
- R6: While a key stays held after the confirmation, passes repeat with buzz low, and the call ends only after a pass finds no key.
- R7: A call whose first pass finds no key ends without a tone and leaves key_code unchanged.
- R8: done is high for exactly one cycle per call, one cycle after the final empty pass, with all rows high. A scan_req arriving while a call is in progress is ignored.
- R9: After reset, key_code is 8'h00, done and buzz are low, and all rows are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_req | input | 1 | Starts a call when the block is idle |
| col_n | input | 3 | Active-low column lines |
| row_n | output | 4 | Active-low row drives |
| buzz | output | 1 | Buzzer drive |
| key_code | output | 8 | Stored ASCII key character |
| done | output | 1 | One-cycle completion strobe |

## Verification
A pass lasts 4*(SETTLE_CLKS+2) cycles plus one decision cycle. A tone burst follows the decision edge at once and lasts 2*MS_CLKS*BEEP_COUNT cycles. done follows the decision of the first empty pass by exactly one cycle. The bench's timeline model counts these positions with plain integers from the cycle scan_req is taken. It compares rows, buzzer, strobe and character on every falling edge, half a cycle away from the edge that updates them. Directed calls also count tone edges and check the character returned at each strobe.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int NROWS = 4;
    localparam int NCOLS = 3;

    typedef logic [7:0] ascii_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_GAP,
        ST_EVAL,
        ST_BEEP,
        ST_FIN
    } scan_st_e;

    typedef struct packed {
        logic   vld;
        ascii_t code;
    } hit_t;

    // Telephone layout: digits 1..9 on the upper three rows, then * 0 #
    function automatic ascii_t key_ascii(input logic [1:0] r, input logic [1:0] c);
        ascii_t res;
        if (r != 2'd3) begin
            res = 8'h31 + ({6'd0, r} * 8'd3) + {6'd0, c};
        end else begin
            case (c)
                2'd0:    res = 8'h2A;
                2'd1:    res = 8'h30;
                default: res = 8'h23;
            endcase
        end
        return res;
    endfunction

endpackage

// File: rtl/kp_encoder.sv
module kp_encoder
    import kp_pkg::*;
(
    input  logic [1:0]       row_idx,
    input  logic [NCOLS-1:0] col_n,
    output hit_t             hit
);

    // Ascending column order: the highest low column is the one kept
    always_comb begin
        hit = '0;
        for (int c = 0; c < NCOLS; c++) begin
            if (!col_n[c]) begin
                hit.vld  = 1'b1;
                hit.code = key_ascii(row_idx, 2'(c));
            end
        end
    end

endmodule

// File: rtl/kp_beeper.sv
module kp_beeper #(
    parameter int MS_CLKS    = 50000,
    parameter int BEEP_COUNT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic buzz,
    output logic fin
);

    localparam int MSW = $clog2(MS_CLKS + 1);
    localparam int BW  = $clog2(BEEP_COUNT + 1);

    logic           active;
    logic           level;
    logic [MSW-1:0] ms_cnt;
    logic [BW-1:0]  n_cnt;
    logic           ms_last;
    logic           n_last;

    assign ms_last = (ms_cnt == MSW'(MS_CLKS - 1));
    assign n_last  = (n_cnt == BW'(BEEP_COUNT - 1));
    assign fin     = active && !level && ms_last && n_last;
    assign buzz    = active && level;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            level  <= 1'b0;
            ms_cnt <= '0;
            n_cnt  <= '0;
        end else if (start) begin
            active <= 1'b1;
            level  <= 1'b1;
            ms_cnt <= '0;
            n_cnt  <= '0;
        end else if (active) begin
            if (ms_last) begin
                ms_cnt <= '0;
                if (level) begin
                    level <= 1'b0;
                end else if (n_last) begin
                    active <= 1'b0;
                end else begin
                    n_cnt <= n_cnt + 1'b1;
                    level <= 1'b1;
                end
            end else begin
                ms_cnt <= ms_cnt + 1'b1;
            end
        end
    end

    AST_SILENT_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
        fin |=> !buzz) else $error("buzzer still on after burst"); // R5

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kp_pkg::*;
#(
    parameter int SETTLE_CLKS = 4,
    parameter int MS_CLKS     = 50000,
    parameter int BEEP_COUNT  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scan_req,
    input  logic [2:0] col_n,
    output logic [3:0] row_n,
    output logic       buzz,
    output logic [7:0] key_code,
    output logic       done
);

    localparam int SW = $clog2(SETTLE_CLKS + 2);

    scan_st_e      st;
    logic [1:0]    row_q;
    logic [SW-1:0] cnt;
    hit_t          hit_q;
    hit_t          enc_hit;
    ascii_t        key_q;
    logic          beeped;
    logic          start_beep;
    logic          beep_fin;

    kp_encoder u_enc (
        .row_idx (row_q),
        .col_n   (col_n),
        .hit     (enc_hit)
    );

    kp_beeper #(
        .MS_CLKS    (MS_CLKS),
        .BEEP_COUNT (BEEP_COUNT)
    ) u_beep (
        .clk   (clk),
        .rst   (rst),
        .start (start_beep),
        .buzz  (buzz),
        .fin   (beep_fin)
    );

    assign start_beep = (st == ST_EVAL) && hit_q.vld && !beeped;
    assign done       = (st == ST_FIN);
    assign key_code   = key_q;

    always_comb begin
        row_n = '1;
        if (st == ST_ROW) row_n[row_q] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            row_q  <= '0;
            cnt    <= '0;
            hit_q  <= '0;
            key_q  <= '0;
            beeped <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (scan_req) begin
                    st     <= ST_ROW;
                    row_q  <= '0;
                    cnt    <= '0;
                    hit_q  <= '0;
                    beeped <= 1'b0;
                end
                ST_ROW: begin
                    if (cnt == SW'(SETTLE_CLKS)) begin
                        if (enc_hit.vld) hit_q <= enc_hit;
                        st <= ST_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (row_q == 2'(NROWS - 1)) begin
                        st <= ST_EVAL;
                    end else begin
                        row_q <= row_q + 1'b1;
                        cnt   <= '0;
                        st    <= ST_ROW;
                    end
                end
                ST_EVAL: begin
                    if (!hit_q.vld) begin
                        st <= ST_FIN;
                    end else if (beeped) begin
                        st    <= ST_ROW;
                        row_q <= '0;
                        cnt   <= '0;
                        hit_q <= '0;
                    end else begin
                        key_q  <= hit_q.code;
                        beeped <= 1'b1;
                        st     <= ST_BEEP;
                    end
                end
                ST_BEEP: if (beep_fin) begin
                    st    <= ST_ROW;
                    row_q <= '0;
                    cnt   <= '0;
                    hit_q <= '0;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_ROW_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
        (row_n != 4'hF) |-> ($past(row_n) == 4'hF || $past(row_n) == row_n))
        else $error("row change without idle gap"); // R1

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R8

    AST_DONE_QUIET_LINES: assert property (@(posedge clk) disable iff (rst)
        done |-> (row_n == 4'hF && !buzz)) else $error("lines active at done"); // R8

    AST_KEY_CHANGE_BEEPS: assert property (@(posedge clk) disable iff (rst)
        !$stable(key_code) |-> buzz) else $error("key changed without beep"); // R5

endmodule

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;

    localparam int SETTLE = 2;
    localparam int MS     = 3;
    localparam int BEEPS  = 4;
    localparam int PER    = SETTLE + 2;
    localparam int BURST  = 2 * MS * BEEPS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_req = 1'b0;
    logic [2:0] col_n;
    logic [3:0] row_n;
    logic       buzz;
    logic [7:0] key_code;
    logic       done;
    logic [11:0] keys = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    string layout = "123456789*0#";

    always #10 clk = ~clk;

    keypad_scanner #(
        .SETTLE_CLKS (SETTLE),
        .MS_CLKS     (MS),
        .BEEP_COUNT  (BEEPS)
    ) i_keypad_scanner (
        .clk      (clk),
        .rst      (rst),
        .scan_req (scan_req),
        .col_n    (col_n),
        .row_n    (row_n),
        .buzz     (buzz),
        .key_code (key_code),
        .done     (done)
    );

    // Keypad switches: a closed key joins its row to its column
    always_comb begin
        col_n = '1;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 3; c++)
                if (!row_n[r] && keys[r*3+c]) col_n[c] = 1'b0;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Timeline model: 0 idle, 1 pass, 2 decide, 3 burst, 4 strobe
    int         m_phase = 0;
    int         m_p = 0;
    int         m_k = 0;
    logic [7:0] m_hit = 0;
    logic [7:0] m_key = 0;
    bit         m_beeped = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_phase = 0; m_p = 0; m_k = 0; m_hit = 0; m_key = 0; m_beeped = 0;
        end else begin
            case (m_phase)
                0: if (scan_req) begin
                    m_phase = 1; m_p = 0; m_hit = 0; m_beeped = 0;
                end
                1: begin
                    if (m_p % PER == SETTLE)
                        for (int c = 0; c < 3; c++)
                            if (keys[(m_p/PER)*3+c]) m_hit = layout[(m_p/PER)*3+c];
                    if (m_p == 4*PER-1) m_phase = 2;
                    else m_p++;
                end
                2: begin
                    if (m_hit == 0) m_phase = 4;
                    else if (m_beeped) begin
                        m_phase = 1; m_p = 0; m_hit = 0;
                    end else begin
                        m_key = m_hit; m_beeped = 1; m_phase = 3; m_k = 0;
                    end
                end
                3: begin
                    if (m_k == BURST-1) begin
                        m_phase = 1; m_p = 0; m_hit = 0;
                    end else m_k++;
                end
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] e_rows;
            e_rows = 4'hF;
            if (m_phase == 1 && (m_p % PER) <= SETTLE) e_rows[m_p/PER] = 1'b0;
            check("R1/R2 row_n", 32'(row_n), 32'(e_rows));
            check("R5 buzz", 32'(buzz), 32'(m_phase == 3 && (m_k % (2*MS)) < MS));
            check("R8 done", 32'(done), 32'(m_phase == 4));
            check("R7 key_code", 32'(key_code), 32'(m_key));
        end
    end

    // One call: press pattern k, release at cycle rel, optional extra request at cycle xr
    task automatic call(input logic [11:0] k, input int rel, input int xr,
                        input logic [7:0] exp_key, input int exp_beeps, input string req);
        int n = 0;
        int rises = 0;
        logic prev = 1'b0;
        bit got = 0;
        @(negedge clk); #1;
        keys = k; scan_req = 1'b1;
        @(negedge clk); #1;
        scan_req = 1'b0;
        while (n < 600 && !got) begin
            @(negedge clk); #1;
            n++;
            if (buzz && !prev) rises++;
            prev = buzz;
            if (n == rel) keys = '0;
            scan_req = (n == xr);
            if (done) got = 1;
        end
        scan_req = 1'b0;
        keys = '0;
        check({req, " strobe seen"}, 32'(got), 32'd1);
        check({req, " key at strobe"}, 32'(key_code), 32'(exp_key));
        check({req, " tone count"}, 32'(rises), 32'(exp_beeps));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        // R9 reset state
        check("R9 key after reset", 32'(key_code), 32'h00);
        check("R9 rows after reset", 32'(row_n), 32'hF);
        check("R9 buzz after reset", 32'(buzz), 32'd0);
        check("R9 done after reset", 32'(done), 32'd0);

        // R7 empty call keeps reset value
        call(12'h000, 0, 0, 8'h00, 0, "R7 empty");
        // R5 key '5' pressed, released during burst
        call(12'h010, 25, 0, 8'h35, BEEPS, "R5 key 5");
        // R6 key '8' held well past the burst: one burst only
        call(12'h080, 150, 0, 8'h38, BEEPS, "R6 held 8");
        // R7 empty call keeps '8'
        call(12'h000, 0, 0, 8'h38, 0, "R7 keep 8");
        // R3 every key alone
        for (int i = 0; i < 12; i++)
            call(12'(1 << i), 25, 0, layout[i], BEEPS, "R3 map");
        // R4 priority across rows and within a row
        call(12'h901, 25, 0, 8'h23, BEEPS, "R4 rows 1 9 #");
        call(12'h028, 25, 0, 8'h36, BEEPS, "R4 cols 4 6");
        call(12'h003, 25, 0, 8'h32, BEEPS, "R4 cols 1 2");
        // R8 request during a call is ignored: no second strobe afterwards
        call(12'h004, 25, 8, 8'h33, BEEPS, "R8 busy req");
        begin
            int extra = 0;
            repeat (40) begin
                @(negedge clk); #1;
                if (done) extra++;
            end
            check("R8 no extra strobe", 32'(extra), 32'd0);
            check("R1 rows idle", 32'(row_n), 32'hF);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule